// File: doc/BRIEF.md
# Aspect-Ratio Status Change Interrupt Register

This block is the read-back status register of a host-controlled audio/video switch. Two external comparator decoders each report a 2-bit aspect-ratio code for one peripheral input. The block brings both codes into its clock domain through a two-flop synchroniser. It shows them in one 8-bit status byte and raises an interrupt flag when either code changes while the interrupt is armed.

The host arms the interrupt by writing 1 to bit 7 of control register address 4. Arming is one-shot: when the flag is set, the arm bit clears itself. A status read, signalled by a one-cycle read strobe, clears the flag. If a code change and a read fall in the same cycle, the flag stays set, so the event is not lost. An active-high interrupt line follows the flag. The serial bus engine and the analog comparators lie outside this block.

Top module: `avsw_stat_irq`

## Requirements
- R1: Field 0 (code from input A) appears at status bits 1:0 and field 1 (input B) at bits 3:2. The code is reported unchanged, two clock edges after it appears at the input. Codes are 01 = level below about 2 V, 10 = 16:9, 11 = 4:3, and 00 is a legal unused value.
- R2: Status bits 7:5 always read 0.
- R3: While reset is low and after it, the status byte reads 00h, the interrupt is disarmed and `irq` is low.
- R4: When armed, a change of either field sets the flag (status bit 4) on the third clock edge after the input change.
- R5: A write to address 4 with data bit 7 = 1 arms the interrupt. A write to address 4 with bit 7 = 0 disarms it.
- R6: A write to any address other than 4 has no effect on arming.
- R7: Setting the flag clears the arm, so later changes raise no new flag until the host arms again.
- R8: A read strobe clears the flag on the next edge. The status byte seen during the strobe cycle still holds the flag value from before the clear.
- R9: If a field change is detected while armed in the same cycle as a read strobe, the flag stays set.
- R10: While disarmed, field changes never set the flag, and arming later does not report changes made before the arm.
- R11: `irq` always equals status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fld_in | input | 4 | Asynchronous field codes, field i at bits [2i+1:2i] |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | 3 | Control register address |
| wr_data | input | 8 | Control register write data; bit 7 of address 4 is the arm bit |
| rd_stb | input | 1 | One-cycle status read strobe |
| rd_data | output | 8 | Status byte: fields, flag in bit 4, zeros above |
| irq | output | 1 | Active-high interrupt, equal to the flag |

## Verification
The assertions assume that the read strobe and the control write are single-cycle pulses driven synchronously to `clk`. They also assume the field inputs hold steady for at least a few cycles so the synchroniser resolves them. The bench drives every input half a cycle away from the active edge and keeps each field code stable for three or more cycles between changes. The bench never issues an arm write in the same cycle as a pending change, so the change-over-write priority is covered only by the assertion that a rising flag leaves the block disarmed.

// File: rtl/avsw_stat_pkg.sv
// Package: shared constants and code type for the status interrupt register.
// Assumes an 8-bit register data path and 2-bit field codes.
package avsw_stat_pkg;
    localparam int FLD_W      = 2;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;

    // Aspect-ratio code carried in each status field.
    typedef enum logic [FLD_W-1:0] {
        CODE_NONE = 2'b00,
        CODE_LOW  = 2'b01,
        CODE_WIDE = 2'b10,
        CODE_STD  = 2'b11
    } fld_code_e;
endpackage

// File: rtl/avsw_sync.sv
// Module: multi-stage synchroniser for a W-bit asynchronous code.
// Assumes the code is stable long enough that bit skew settles within STAGES.
module avsw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= din;
                end
            end else begin : g_next
                // Shift the code one stage further along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/avsw_chg_det.sv
// Module: per-field change detector.
// It keeps the previous synchronised code of each field and flags any
// difference. Assumes the codes come from the synchroniser output.
module avsw_chg_det #(
    parameter int N_FLD = 2,
    parameter int FLD_W = 2,
    localparam int TOT_W = N_FLD * FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] cur,
    output logic             chg_any
);
    logic [TOT_W-1:0] prev_q;
    logic [N_FLD-1:0] diff;

    // Track the last seen code of every field on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    generate
        for (genvar f = 0; f < N_FLD; f++) begin : g_cmp
            // Compare one field against its previous value.
            always_comb diff[f] = (cur[f*FLD_W +: FLD_W] != prev_q[f*FLD_W +: FLD_W]);
        end
    endgenerate

    // Combine the per-field differences.
    always_comb chg_any = |diff;
endmodule

// File: rtl/avsw_irq_ctrl.sv
// Module: arm bit and interrupt flag.
// A change while armed sets the flag and disarms. Otherwise a control write
// updates the arm bit and a read strobe clears the flag.
// Assumes wr_en and rd_stb are single-cycle pulses.
module avsw_irq_ctrl #(
    parameter int                ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_any,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              arm_bit,
    input  logic              rd_stb,
    output logic              arm_q,
    output logic              flag_q
);
    logic ctrl_hit;
    logic fire;

    // Decode the control write and the change event.
    always_comb begin
        ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
        fire     = chg_any && arm_q;
    end

    // Update the arm bit; a firing event has priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (fire)     arm_q <= 1'b0;
        else if (ctrl_hit) arm_q <= arm_bit;
    end

    // Update the flag; a firing event has priority over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (fire)   flag_q <= 1'b1;
        else if (rd_stb) flag_q <= 1'b0;
    end
endmodule

// File: rtl/avsw_stat_irq.sv
// Module: top of the aspect-ratio status change interrupt register.
// It synchronises each field, detects changes, and assembles the status byte
// as fields in the low bits, the flag just above them, and zeros on top.
// Assumes the host sees rd_data combinationally during the rd_stb cycle.
module avsw_stat_irq
    import avsw_stat_pkg::*;
#(
    parameter int                N_FLD     = 2,
    parameter int                STAGES    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd4,
    parameter int                ARM_BIT   = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_FLD*FLD_W-1:0]  fld_in,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_stb,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    irq
);
    localparam int TOT_W    = N_FLD * FLD_W;
    localparam int FLAG_POS = TOT_W;

    logic [TOT_W-1:0] fld_sync;
    logic             chg_any;
    logic             arm_q;
    logic             flag_q;

    generate
        for (genvar f = 0; f < N_FLD; f++) begin : g_fld
            avsw_sync #(.W(FLD_W), .STAGES(STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (fld_in[f*FLD_W +: FLD_W]),
                .dout  (fld_sync[f*FLD_W +: FLD_W])
            );
        end
    endgenerate

    avsw_chg_det #(.N_FLD(N_FLD), .FLD_W(FLD_W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (fld_sync),
        .chg_any (chg_any)
    );

    avsw_irq_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_any (chg_any),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .arm_bit (wr_data[ARM_BIT]),
        .rd_stb  (rd_stb),
        .arm_q   (arm_q),
        .flag_q  (flag_q)
    );

    // Assemble the status byte with the unused upper bits forced to zero.
    always_comb begin
        rd_data           = '0;
        rd_data[TOT_W-1:0] = fld_sync;
        rd_data[FLAG_POS] = flag_q;
    end

    // Drive the interrupt line from the flag.
    assign irq = flag_q;
endmodule

// File: rtl/avsw_stat_irq_chk.sv
// Checker: temporal properties of the status interrupt register, bound to the top.
module avsw_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic       arm_q
);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:5] == 3'b000);

    assert_irq_is_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rd_data[4]);

    assert_rise_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(arm_q));

    assert_rise_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !arm_q);

    assert_no_flag_disarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !irq) |=> !irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && irq && !arm_q) |=> !irq);

    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stb) |=> irq);
endmodule

bind avsw_stat_irq avsw_stat_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .irq     (irq),
    .rd_data (rd_data),
    .arm_q   (arm_q)
);

// File: tb/avsw_stat_irq_tb.sv
module avsw_stat_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fld_in = 4'h0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    avsw_stat_irq u_dut (
        .clk(clk), .rst_n(rst_n), .fld_in(fld_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    // Field patterns, each followed by the expected disarmed status byte.
    localparam logic [11:0] VEC [8] = '{
        {4'b0001, 8'h01}, {4'b0110, 8'h06}, {4'b1011, 8'h0B}, {4'b1100, 8'h0C},
        {4'b0111, 8'h07}, {4'b1110, 8'h0E}, {4'b0000, 8'h00}, {4'b1101, 8'h0D}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        // R3: reset state
        chk(rd_data == 8'h00 && irq == 1'b0, "R3", rd_data, 0);
        rst_n = 1'b1;
        tick(2);
        chk(rd_data == 8'h00 && irq == 1'b0, "R3", rd_data, 0);

        // R1 R2 R10: vector walk while disarmed
        for (int i = 0; i < 8; i++) begin
            fld_in = VEC[i][11:8];
            tick(3);
            chk(rd_data == VEC[i][7:0], "R1/R2 vector", rd_data, VEC[i][7:0]);
            chk(irq == 1'b0, "R10 vector", irq, 0);
        end

        // R1: two-edge latency
        fld_in = 4'b1011;
        tick(1);
        chk(rd_data[3:0] == 4'b1101, "R1 latency-1", rd_data, 4'hD);
        tick(1);
        chk(rd_data[3:0] == 4'b1011, "R1 latency-2", rd_data, 4'hB);
        tick(2);

        // R4 R5 R11: armed change sets flag on third edge
        wr(3'd4, 8'h80);
        fld_in = 4'b0111;
        tick(2);
        chk(irq == 1'b0, "R4 early", irq, 0);
        tick(1);
        chk(rd_data == 8'h17, "R4 flag", rd_data, 8'h17);
        chk(irq == rd_data[4], "R11", irq, rd_data[4]);

        // R8: read clears, pre-clear value seen in strobe cycle
        rd_stb = 1'b1;
        chk(rd_data[4] == 1'b1, "R8 pre", rd_data, 8'h17);
        tick(1);
        rd_stb = 1'b0;
        chk(rd_data[4] == 1'b0 && irq == 1'b0, "R8 clear", rd_data, 8'h07);

        // R7: self-disarmed after firing
        fld_in = 4'b1110;
        tick(4);
        chk(irq == 1'b0, "R7", irq, 0);

        // R9: change and read in the same cycle
        wr(3'd4, 8'h80);
        fld_in = 4'b0101;
        tick(3);
        chk(irq == 1'b1, "R9 setup", irq, 1);
        wr(3'd4, 8'h80);
        fld_in = 4'b1010;
        tick(2);
        rd_pulse();
        chk(irq == 1'b1, "R9 kept", irq, 1);
        rd_pulse();
        chk(irq == 1'b0, "R9 cleared", irq, 0);

        // R6: write to another address does not arm
        wr(3'd3, 8'hFF);
        fld_in = 4'b0110;
        tick(4);
        chk(irq == 1'b0, "R6", irq, 0);

        // R5: bit 7 = 0 disarms
        wr(3'd4, 8'h80);
        wr(3'd4, 8'h7F);
        fld_in = 4'b1111;
        tick(4);
        chk(irq == 1'b0, "R5 disarm", irq, 0);

        // R10: change while disarmed is not reported after arming
        fld_in = 4'b0001;
        tick(4);
        wr(3'd4, 8'h80);
        tick(4);
        chk(irq == 1'b0, "R10 stale", irq, 0);
        fld_in = 4'b0011;
        tick(3);
        chk(irq == 1'b1 && rd_data == 8'h13, "R5 arm", rd_data, 8'h13);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule